// File: doc/BRIEF.md
# Printer Port Interrupt Generator

This block produces the interrupt output of a parallel printer port and the interrupt-related bits of its status register. It watches the printer's acknowledge line, host register accesses (control register writes, port data writes, status register reads) and the FIFO level flags. From these it keeps two pending flags. The latched flag is set by a control write or an acknowledge falling edge, and is cleared by a status read. The tracking flag is set by a control write and cleared by a port write.

A static mode input picks which flag drives the pin when the source select is in its normal setting. The source select can also route FIFO empty or FIFO full to the pin. A polarity bit flips the pin level. An enable bit drives a separate output-enable, so the pad driver outside the block can float the pin. The status register reads the latched flag, the tracking flag and a FIFO-empty view from this block. All outputs are registered, and the asynchronous acknowledge input passes through a synchroniser whose depth is a parameter.

Top module: `prn_irq_ctrl`

## Requirements
- R1: With `track_mode`=0 and source select 00, a control write with bit 0 = 1 drives the interrupt to its active level. It returns to idle only after a status read ends, which is the falling edge of `stat_rd`. A port write does not clear it.
- R2: With `track_mode`=1 and source select 00, a control write with bit 0 = 1 drives the interrupt active and a port write returns it to idle. A status read has no effect on the pin.
- R3: `stat_lo[2]` reads 0 while the latched flag is pending and 1 otherwise. An `ack_n` falling edge sets the flag, and so does a control write with bit 0 = 1. A control write with bit 0 = 0 changes nothing.
- R4: `stat_b6` reads 0 while the tracking flag is pending and 1 otherwise, in both settings of `track_mode`.
- R5: Source select 01 and 11 make the interrupt active exactly while `fifo_empty` is 1. Source select 10 makes it active exactly while `fifo_full` is 1.
- R6: With `pol_inv`=0 the active level of `irq_o` is 0 and the idle level is 1. With `pol_inv`=1 both levels are inverted.
- R7: `irq_oe` is 1 exactly when `irq_en` was 1 on the previous clock.
- R8: `stat_lo[1:0]` reads 11 for source select 00, 01 and 10. For source select 11 both bits read the inverse of `fifo_empty`.
- R9: When an acknowledge falling edge and the end of a status read land in the same cycle, the latched flag stays pending, because setting has priority over clearing.
- R10: After reset, `irq_o`=1, `irq_oe`=0, `stat_lo`=111 and `stat_b6`=1, with both flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| track_mode | input | 1 | Static select: 0 latched, 1 tracking |
| ack_n | input | 1 | Printer acknowledge, active low, asynchronous |
| ctrl_wr | input | 1 | One-cycle pulse for a control register write |
| ctrl_bit0 | input | 1 | Bit 0 of the control write data |
| port_wr | input | 1 | One-cycle pulse for a port data register write |
| stat_rd | input | 1 | High while the host reads the status register |
| irq_en | input | 1 | Interrupt output enable (control bit 4) |
| src_sel | input | 2 | Interrupt source select |
| pol_inv | input | 1 | Invert interrupt polarity |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| irq_o | output | 1 | Interrupt level to the pad |
| irq_oe | output | 1 | Pad output enable for the interrupt |
| stat_lo | output | 3 | Status bits 2..0 |
| stat_b6 | output | 1 | Status bit 6 (tracking flag view) |

## Verification
The latched flag has one setter and one clearer that can fall in the same cycle: the acknowledge falling edge, once it has passed the synchroniser, and the end of a status read. The bench drops `ack_n` and then lowers `stat_rd` exactly two clocks later. Both events then reach the flag on the same edge. The check passes only if `stat_lo[2]` and the pin still show the interrupt as pending afterwards, which confirms that setting has priority over clearing.

// File: rtl/prn_irq_pkg.sv
package prn_irq_pkg;
  typedef enum logic [1:0] {
    SRC_HSHAKE  = 2'b00,
    SRC_EMPTY   = 2'b01,
    SRC_FULL    = 2'b10,
    SRC_EMPTY_S = 2'b11
  } irq_src_e;

  localparam int unsigned STAT_LO_W = 3;
endpackage

// File: rtl/prn_irq_sync.sv
module prn_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic fall
);
  logic synced;
  logic prev;

  generate
    if (STAGES <= 1) begin : g_one
      logic s;
      always_ff @(posedge clk) begin
        if (rst) s <= 1'b1;
        else     s <= async_n;
      end
      assign synced = s;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], async_n};
      end
      assign synced = sh[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= synced;
  end

  assign fall = prev & ~synced;
endmodule

// File: rtl/prn_irq_state.sv
module prn_irq_state (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic ctrl_bit0,
  input  logic port_wr,
  input  logic stat_rd,
  input  logic ack_fall,
  output logic lat_pend,
  output logic trk_pend,
  output logic rd_q
);
  logic arm;
  logic rd_end;

  assign arm    = ctrl_wr & ctrl_bit0;
  assign rd_end = rd_q & ~stat_rd;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= stat_rd;
  end

  // set has priority over the read-release clear
  always_ff @(posedge clk) begin
    if (rst)                   lat_pend <= 1'b0;
    else if (arm || ack_fall)  lat_pend <= 1'b1;
    else if (rd_end)           lat_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          trk_pend <= 1'b0;
    else if (arm)     trk_pend <= 1'b1;
    else if (port_wr) trk_pend <= 1'b0;
  end
endmodule

// File: rtl/prn_irq_out.sv
module prn_irq_out
  import prn_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 track_mode,
  input  logic                 lat_pend,
  input  logic                 trk_pend,
  input  logic                 irq_en,
  input  logic [1:0]           src_sel,
  input  logic                 pol_inv,
  input  logic                 fifo_empty,
  input  logic                 fifo_full,
  output logic                 irq_o,
  output logic                 irq_oe,
  output logic [STAT_LO_W-1:0] stat_lo,
  output logic                 stat_b6
);
  logic active;
  logic [1:0] lo_bits;

  always_comb begin
    unique case (irq_src_e'(src_sel))
      SRC_HSHAKE:  active = track_mode ? trk_pend : lat_pend;
      SRC_FULL:    active = fifo_full;
      default:     active = fifo_empty;
    endcase
  end

  assign lo_bits = (irq_src_e'(src_sel) == SRC_EMPTY_S) ? {2{~fifo_empty}} : 2'b11;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b1;
      irq_oe  <= 1'b0;
      stat_lo <= '1;
      stat_b6 <= 1'b1;
    end else begin
      irq_o   <= pol_inv ? active : ~active;
      irq_oe  <= irq_en;
      stat_lo <= {~lat_pend, lo_bits};
      stat_b6 <= ~trk_pend;
    end
  end
endmodule

// File: rtl/prn_irq_ctrl.sv
module prn_irq_ctrl
  import prn_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 track_mode,
  input  logic                 ack_n,
  input  logic                 ctrl_wr,
  input  logic                 ctrl_bit0,
  input  logic                 port_wr,
  input  logic                 stat_rd,
  input  logic                 irq_en,
  input  logic [1:0]           src_sel,
  input  logic                 pol_inv,
  input  logic                 fifo_empty,
  input  logic                 fifo_full,
  output logic                 irq_o,
  output logic                 irq_oe,
  output logic [STAT_LO_W-1:0] stat_lo,
  output logic                 stat_b6
);
  logic ack_fall;
  logic lat_pend;
  logic trk_pend;
  logic rd_q;

  prn_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_n(ack_n), .fall(ack_fall)
  );

  prn_irq_state u_state (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_bit0(ctrl_bit0),
    .port_wr(port_wr), .stat_rd(stat_rd), .ack_fall(ack_fall),
    .lat_pend(lat_pend), .trk_pend(trk_pend), .rd_q(rd_q)
  );

  prn_irq_out u_out (
    .clk(clk), .rst(rst), .track_mode(track_mode), .lat_pend(lat_pend),
    .trk_pend(trk_pend), .irq_en(irq_en), .src_sel(src_sel),
    .pol_inv(pol_inv), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .irq_o(irq_o), .irq_oe(irq_oe), .stat_lo(stat_lo), .stat_b6(stat_b6)
  );
endmodule

// File: rtl/prn_irq_ctrl_chk.sv
module prn_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_wr,
  input logic       ctrl_bit0,
  input logic       port_wr,
  input logic       stat_rd,
  input logic       irq_en,
  input logic [1:0] src_sel,
  input logic       pol_inv,
  input logic       fifo_full,
  input logic       ack_fall,
  input logic       rd_q,
  input logic       lat_pend,
  input logic       trk_pend,
  input logic       irq_o,
  input logic       irq_oe,
  input logic [2:0] stat_lo
);
  assert_arm_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_bit0) |=> lat_pend);

  assert_portwr_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (port_wr && !(ctrl_wr && ctrl_bit0)) |=> !trk_pend);

  assert_rd_clears_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_q && !stat_rd && !ack_fall && !(ctrl_wr && ctrl_bit0)) |=> !lat_pend);

  assert_both_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_q && !stat_rd && ack_fall) |=> lat_pend);

  assert_oe_on_R7: assert property (@(posedge clk) disable iff (rst)
    irq_en |=> irq_oe);

  assert_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_oe);

  assert_full_low_R6: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b10 && fifo_full && !pol_inv) |=> !irq_o);

  assert_lo_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (src_sel != 2'b11) |=> (stat_lo[1:0] == 2'b11));
endmodule

bind prn_irq_ctrl prn_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_bit0(ctrl_bit0),
  .port_wr(port_wr), .stat_rd(stat_rd), .irq_en(irq_en), .src_sel(src_sel),
  .pol_inv(pol_inv), .fifo_full(fifo_full), .ack_fall(ack_fall), .rd_q(rd_q),
  .lat_pend(lat_pend), .trk_pend(trk_pend), .irq_o(irq_o), .irq_oe(irq_oe),
  .stat_lo(stat_lo)
);

// File: tb/prn_irq_ctrl_bench.sv
module prn_irq_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic track_mode = 1'b0, ack_n = 1'b1, ctrl_wr = 1'b0, ctrl_bit0 = 1'b0;
  logic port_wr = 1'b0, stat_rd = 1'b0, irq_en = 1'b0, pol_inv = 1'b0;
  logic fifo_empty = 1'b0, fifo_full = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic irq_o, irq_oe, stat_b6;
  logic [2:0] stat_lo;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prn_irq_ctrl u_prn_irq_ctrl (
    .clk(clk), .rst(rst), .track_mode(track_mode), .ack_n(ack_n),
    .ctrl_wr(ctrl_wr), .ctrl_bit0(ctrl_bit0), .port_wr(port_wr),
    .stat_rd(stat_rd), .irq_en(irq_en), .src_sel(src_sel), .pol_inv(pol_inv),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .irq_o(irq_o),
    .irq_oe(irq_oe), .stat_lo(stat_lo), .stat_b6(stat_b6)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic b0);
    ctrl_wr = 1'b1; ctrl_bit0 = b0; tick(1);
    ctrl_wr = 1'b0; ctrl_bit0 = 1'b0; tick(3);
  endtask

  task automatic wr_port();
    port_wr = 1'b1; tick(1); port_wr = 1'b0; tick(3);
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1; tick(2); stat_rd = 1'b0; tick(3);
  endtask

  task automatic t_reset();
    chk("R10 irq_o", irq_o, 1); chk("R10 irq_oe", irq_oe, 0);
    chk("R10 stat_lo", stat_lo, 3'b111); chk("R10 stat_b6", stat_b6, 1);
  endtask

  task automatic t_latched();
    track_mode = 0; irq_en = 1; src_sel = 0; pol_inv = 0; tick(2);
    wr_ctrl(0);
    chk("R3 bit0=0 no set", stat_lo[2], 1); chk("R3 bit0=0 pin", irq_o, 1);
    wr_ctrl(1);
    chk("R1 set pin", irq_o, 0); chk("R3 set bit2", stat_lo[2], 0);
    wr_port();
    chk("R1 port wr keeps", irq_o, 0);
    stat_rd = 1'b1; tick(3);
    chk("R1 held during read", irq_o, 0);
    stat_rd = 1'b0; tick(3);
    chk("R1 clear pin", irq_o, 1); chk("R3 clear bit2", stat_lo[2], 1);
  endtask

  task automatic t_ack();
    ack_n = 0; tick(5);
    chk("R3 ack fall bit2", stat_lo[2], 0); chk("R1 ack pin", irq_o, 0);
    ack_n = 1; tick(5);
    chk("R3 ack rise keeps", stat_lo[2], 0);
    rd_stat();
    chk("R3 read clears", stat_lo[2], 1);
  endtask

  task automatic t_track();
    track_mode = 1; tick(2);
    wr_ctrl(1);
    chk("R2 set pin", irq_o, 0); chk("R4 b6 track", stat_b6, 0);
    rd_stat();
    chk("R2 read no effect", irq_o, 0);
    wr_port();
    chk("R2 port clears", irq_o, 1); chk("R4 b6 idle", stat_b6, 1);
    track_mode = 0; tick(2);
    wr_ctrl(1);
    chk("R4 b6 latched mode", stat_b6, 0);
    wr_port();
    chk("R4 b6 cleared latched mode", stat_b6, 1);
    rd_stat();
    chk("R1 cleanup", irq_o, 1);
  endtask

  task automatic t_fifo();
    src_sel = 2'b01; fifo_empty = 1; tick(3);
    chk("R5 empty src01", irq_o, 0); chk("R8 lo src01", stat_lo[1:0], 2'b11);
    fifo_empty = 0; tick(3);
    chk("R5 not empty src01", irq_o, 1);
    src_sel = 2'b10; fifo_full = 1; tick(3);
    chk("R5 full src10", irq_o, 0);
    fifo_full = 0; tick(3);
    chk("R5 not full src10", irq_o, 1);
    src_sel = 2'b11; fifo_empty = 1; tick(3);
    chk("R5 empty src11", irq_o, 0); chk("R8 lo src11 empty", stat_lo[1:0], 2'b00);
    fifo_empty = 0; tick(3);
    chk("R8 lo src11 data", stat_lo[1:0], 2'b11);
    src_sel = 2'b00; fifo_empty = 1; tick(3);
    chk("R8 lo src00", stat_lo[1:0], 2'b11);
    fifo_empty = 0; tick(1);
  endtask

  task automatic t_pol();
    src_sel = 2'b10; pol_inv = 1; fifo_full = 1; tick(3);
    chk("R6 inv active", irq_o, 1);
    fifo_full = 0; tick(3);
    chk("R6 inv idle", irq_o, 0);
    pol_inv = 0; src_sel = 2'b00; tick(3);
    chk("R6 normal idle", irq_o, 1);
  endtask

  task automatic t_oe();
    irq_en = 0; tick(2);
    chk("R7 oe off", irq_oe, 0);
    irq_en = 1; tick(2);
    chk("R7 oe on", irq_oe, 1);
  endtask

  task automatic t_coincide();
    track_mode = 0; src_sel = 0;
    stat_rd = 1; tick(2);
    ack_n = 0; tick(2);
    stat_rd = 0; tick(4);
    chk("R9 set wins bit2", stat_lo[2], 0); chk("R9 set wins pin", irq_o, 0);
    ack_n = 1; tick(3);
    rd_stat();
    chk("R9 later read clears", stat_lo[2], 1);
  endtask

  initial begin
    tick(3); rst = 0; tick(2);
    t_reset(); t_latched(); t_ack(); t_track();
    t_fifo(); t_pol(); t_oe(); t_coincide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule